// File: doc/BRIEF.md
# Serial/Parallel FIFO Output Register

This block is the exit stage of one FIFO slice. When the stack beneath it reports a word at its bottom location, the block takes that word in and offers it either as a parallel word or as a bit stream that leaves least significant bit first. A single valid flag tells the consumer that an unread word is present. In parallel use the flag follows the transfer request level. In serial use the flag drops by itself once the last bit has been shifted out.

Every input is sampled on the system clock. The serial output clock is an ordinary input whose HIGH-to-LOW transitions are found by comparing it with its value from the previous cycle. For expanded arrays the block can run as a master slice, where the flag rises as soon as a word is loaded. It can also run as a slave slice, where the flag is held LOW until a release input arrives. The output enables are brought out as signals instead of tri-state pads. A disabled output reads as zero.

Top module: `fifo_exit_stage`

## Requirements
- R1: After reset, `valid`, `ser_en` and `stk_pop` are 0, and `par_q` and `ser_q` read 0.
- R2: A load happens in a cycle where `stk_valid`=1, `xfer_par`=1, `xfer_ser_n`=0 and no word is held. In that cycle `stk_pop` is 1, so a load is blocked while `xfer_ser_n`=1. From the next cycle the word is on `par_q`, and in a master slice (`master`=1) `valid` is 1.
- R3: While `xfer_par` stays 1 after a load, no second load takes place. `stk_pop` stays 0 and `par_q` keeps the loaded word even if `stk_data` changes.
- R4: One cycle after `xfer_par` is sampled 0, `valid` is 0. `par_q` keeps showing the last loaded word until the next load.
- R5: The transfer request is level-sensitive. If data reaches the bottom of the stack while `xfer_par` is already 1, that data is loaded. If `xfer_par` goes 1 and back to 0 with no data present, `valid` stays 0 and nothing is popped.
- R6: After a load, `ser_en` is 1 and `ser_q` presents bit 0 of the word. Each sampled falling edge of `sclk` moves on to the next higher bit. After the W-th edge, `valid` and `ser_en` are 0 and `ser_q` reads 0.
- R7: A falling edge of `sclk` has no effect in two cases: when it is seen in the same cycle as a load, and when it is seen while `valid` is 0. In both cases the next visible serial bit is still bit 0.
- R8: In a slave slice (`master`=0), a loaded word keeps `valid` and `ser_en` at 0 until `rel_in` is sampled 1. From the next cycle `valid` is 1. A fresh load clears any earlier release.
- R9: With `valid` tied back to `xfer_ser_n` and `xfer_par` held at 1, a new word is loaded in the cycle after the W-th shift of the previous word.
- R10: `par_q` reads 0 while `par_oe`=0. `ser_q` reads 0 while `ser_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset of the control state |
| master | input | 1 | 1 = master slice, 0 = slave slice |
| stk_valid | input | 1 | The bottom location of the stack holds a word |
| stk_data | input | W | Word at the bottom of the stack |
| stk_pop | output | 1 | The word at the bottom of the stack is taken this cycle |
| xfer_par | input | 1 | Level-sensitive parallel transfer request |
| xfer_ser_n | input | 1 | Active-low serial transfer request |
| sclk | input | 1 | Serial output clock; shifting happens on its falling edge |
| rel_in | input | 1 | Serial output enable that releases a slave slice |
| par_oe | input | 1 | Parallel output enable |
| par_q | output | W | Parallel data output, 0 when disabled |
| ser_q | output | 1 | Serial data output, 0 when disabled |
| ser_en | output | 1 | Serial output enable |
| valid | output | 1 | The output register holds an unread word |

## Verification
The bench builds the block with W=4. At that width every word value fits into a full sweep of 16 values in both parallel and serial mode, so each bit position is seen shifting out with both polarities. At W=4 the end of a word comes after four edges, which also keeps the serial-completion and tie-back refill corner cases short enough to cover in master and in slave configuration.

// File: rtl/fifo_exit_stage.sv
module fifo_exit_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         master,
  input  logic         stk_valid,
  input  logic [W-1:0] stk_data,
  output logic         stk_pop,
  input  logic         xfer_par,
  input  logic         xfer_ser_n,
  input  logic         sclk,
  input  logic         rel_in,
  input  logic         par_oe,
  output logic [W-1:0] par_q,
  output logic         ser_q,
  output logic         ser_en,
  output logic         valid
);
  localparam int CW = $clog2(W + 1);

  logic          full, rel, sclk_d;
  logic [W-1:0]  word_r, sh_r;
  logic [CW-1:0] left;
  logic          fall, shift, last;

  assign stk_pop = stk_valid & xfer_par & ~xfer_ser_n & ~full;
  assign valid   = full & (master | rel);
  assign fall    = sclk_d & ~sclk;
  assign shift   = valid & fall & ~stk_pop;
  assign last    = shift && (left == CW'(1));

  assign ser_en  = valid;
  assign ser_q   = ser_en & sh_r[0];
  assign par_q   = par_oe ? word_r : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      rel    <= 1'b0;
      sclk_d <= 1'b0;
      word_r <= '0;
      sh_r   <= '0;
      left   <= '0;
    end else begin
      sclk_d <= sclk;
      if (stk_pop) begin
        full   <= 1'b1;
        rel    <= 1'b0;
        word_r <= stk_data;
        sh_r   <= stk_data;
        left   <= CW'(W);
      end else begin
        if (!xfer_par || last) full <= 1'b0;
        if (shift) begin
          sh_r <= sh_r >> 1;
          left <= left - CW'(1);
        end
        if (!full || !xfer_par || last) rel <= 1'b0;
        else if (rel_in)                rel <= 1'b1;
      end
    end
  end

  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stk_pop |=> !stk_pop);

  assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stk_pop |=> $stable(word_r));

  assert_drop_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_par |=> !valid);

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid) && $stable(master)) |-> ($past(stk_pop) || $past(rel_in)));

  assert_last_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!valid && !ser_en && !ser_q));

  assert_slave_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !valid && !rel_in) |=> (master || !valid));
endmodule

// File: tb/tb_fifo_exit_stage.sv
module tb_fifo_exit_stage;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1;
  logic v_drv = 1'b0;
  logic [W-1:0] d_drv = '0;
  logic xfer_par = 1'b0;
  logic tos_drv = 1'b0;
  logic sclk = 1'b0;
  logic rel_in = 1'b0;
  logic par_oe = 1'b1;
  logic tie = 1'b0;
  int   idx = 0;
  logic [W-1:0] words [3];

  logic         stk_valid, stk_pop, xfer_ser_n, ser_q, ser_en, valid;
  logic [W-1:0] stk_data, par_q;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign stk_valid  = tie ? (idx < 2) : v_drv;
  assign stk_data   = tie ? words[idx < 2 ? idx : 0] : d_drv;
  assign xfer_ser_n = tie ? valid : tos_drv;

  always @(posedge clk) if (tie && stk_pop) idx <= idx + 1;

  fifo_exit_stage #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .master(master), .stk_valid(stk_valid),
    .stk_data(stk_data), .stk_pop(stk_pop), .xfer_par(xfer_par),
    .xfer_ser_n(xfer_ser_n), .sclk(sclk), .rel_in(rel_in), .par_oe(par_oe),
    .par_q(par_q), .ser_q(ser_q), .ser_en(ser_en), .valid(valid));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic edge_fall();
    sclk = 1'b1; tick();
    sclk = 1'b0; tick();
  endtask

  task automatic shift_out(input int d, input string tag);
    for (int k = 1; k <= W; k++) begin
      edge_fall();
      chk({tag, " bit"}, int'(ser_q), (k < W) ? ((d >> k) & 1) : 0);
      chk({tag, " valid"}, int'(valid), (k < W) ? 1 : 0);
      chk({tag, " ser_en"}, int'(ser_en), (k < W) ? 1 : 0);
    end
  endtask

  initial begin
    words[0] = 4'b0110; words[1] = 4'b1001; words[2] = 4'b0000;
    repeat (3) tick();
    chk("R1 valid", int'(valid), 0);
    chk("R1 ser_en", int'(ser_en), 0);
    chk("R1 pop", int'(stk_pop), 0);
    chk("R1 par_q", int'(par_q), 0);
    chk("R1 ser_q", int'(ser_q), 0);
    rst_n = 1'b1;
    tick();

    // R2/R3/R4/R10 parallel sweep
    for (int d = 0; d < 16; d++) begin
      v_drv = 1'b1; d_drv = W'(d); tos_drv = 1'b1; xfer_par = 1'b1;
      tick();
      chk("R2 blocked by xfer_ser_n", int'(valid), 0);
      tos_drv = 1'b0; #1;
      chk("R2 pop", int'(stk_pop), 1);
      tick();
      chk("R2 valid", int'(valid), 1);
      chk("R2 par_q", int'(par_q), d);
      d_drv = W'(d ^ 5);
      #1 chk("R3 no pop", int'(stk_pop), 0);
      tick(); tick();
      chk("R3 par_q hold", int'(par_q), d);
      par_oe = 1'b0; #1;
      chk("R10 par_q off", int'(par_q), 0);
      par_oe = 1'b1; xfer_par = 1'b0; v_drv = 1'b0;
      tick();
      chk("R4 valid low", int'(valid), 0);
      chk("R4 par_q kept", int'(par_q), d);
    end

    // R5 data arrives late
    xfer_par = 1'b1; d_drv = 4'hB;
    tick(); tick();
    chk("R5 no data", int'(valid), 0);
    v_drv = 1'b1;
    tick();
    chk("R5 late load", int'(valid), 1);
    chk("R5 late word", int'(par_q), 11);
    xfer_par = 1'b0; v_drv = 1'b0;
    tick();
    // R5 pulse without data
    xfer_par = 1'b1; tick();
    xfer_par = 1'b0; v_drv = 1'b1; d_drv = 4'h3; #1;
    chk("R5 pulse pop", int'(stk_pop), 0);
    tick();
    chk("R5 pulse valid", int'(valid), 0);
    chk("R5 pulse par_q", int'(par_q), 11);
    v_drv = 1'b0;

    // R6 serial sweep, master
    for (int d = 0; d < 16; d++) begin
      v_drv = 1'b1; d_drv = W'(d); xfer_par = 1'b1; tos_drv = 1'b0;
      tick();
      v_drv = 1'b0;
      chk("R6 ser_en", int'(ser_en), 1);
      chk("R6 first bit", int'(ser_q), d & 1);
      shift_out(d, "R6");
    end
    xfer_par = 1'b0; tick();

    // R7 edge coincident with load
    sclk = 1'b1; tick();
    v_drv = 1'b1; d_drv = 4'b1110; xfer_par = 1'b1; sclk = 1'b0;
    tick();
    v_drv = 1'b0;
    chk("R7 load-cycle edge", int'(ser_q), 0);
    tick();
    chk("R7 still bit0", int'(ser_q), 0);
    shift_out(14, "R7");
    xfer_par = 1'b0; tick();

    // R8 slave hold-off and R7 unreleased edges
    master = 1'b0;
    for (int d = 1; d < 16; d += 7) begin
      v_drv = 1'b1; d_drv = W'(d); xfer_par = 1'b1;
      tick();
      v_drv = 1'b0;
      chk("R8 slave valid", int'(valid), 0);
      chk("R8 slave ser_en", int'(ser_en), 0);
      chk("R10 ser_q off", int'(ser_q), 0);
      edge_fall();
      chk("R8 still held", int'(valid), 0);
      rel_in = 1'b1; tick();
      rel_in = 1'b0;
      chk("R8 released", int'(valid), 1);
      chk("R7 unreleased edge ignored", int'(ser_q), d & 1);
      shift_out(d, "R8");
    end
    xfer_par = 1'b0; master = 1'b1; tick();

    // R9 tie-back refill
    tie = 1'b1; xfer_par = 1'b1;
    tick();
    chk("R9 first word", int'(valid), 1);
    chk("R9 first bit", int'(ser_q), 0);
    shift_out(6, "R9 w0");
    tick();
    chk("R9 refill valid", int'(valid), 1);
    chk("R9 refill bit", int'(ser_q), 1);
    shift_out(9, "R9 w1");
    tick();
    chk("R9 stack empty", int'(valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule